// File: doc/BRIEF.md
# Parallel Programming Mode Decoder and Byte Sequencer

This block sits behind the parallel programming pins of a small microcontroller's on-chip program memory. It reads the level of the reset pin, the program-store enable pin and five port control pins. From that combination it selects one of seven set-up operations: program a code byte, program a key byte, program one of three lock bits, verify a code byte, or read a signature byte. Any other combination selects idle.

Each programming operation commits exactly one byte, or one lock bit, per falling edge of the active-low program strobe. The write is issued only when the program-voltage flag is high at that edge and the current lock level allows it. The write strobe to the target array lasts one clock, and the address and data latched at the edge come with it.

A verify read returns the code byte XNOR-ed with the key byte chosen by the six low address bits. The key array therefore shows up only through the code it scrambles. A signature read answers from a fixed table. Both reads drive the data output with an enable, one clock after the inputs are sampled.

Top module: `progModeSeq`

## Requirements
- R1: The mode is decoded only while `pinRst`=1 and `pinPsen`=0. `ctrlPins` is ordered {P2.6, P2.7, P3.3, P3.6, P3.7} and decodes as follows: 01111 program code, 00111 verify, 01101 program key, 00000 signature, 11111 lock bit 1, 11100 lock bit 2, 10110 lock bit 3. Every other combination is idle: it produces no write strobe, and `dataOe` stays 0 with `dataOut` at 00h.
- R2: In program-code mode, a falling edge of `progN` sampled on a clock edge raises `codeWe` for the following clock cycle. In that same cycle, `wrAddr` and `wrData` hold the `addr` and `dataIn` values present at that clock edge.
- R3: In program-key mode, `keyWe` is raised the same way, but only when `addr` is below 40h. For addresses of 40h and above, no strobe is produced.
- R4: The three lock modes raise bit 0, bit 1 or bit 2 of `lockWe` respectively. At most one of `codeWe`, `keyWe` and the `lockWe` bits is high in any cycle.
- R5: No write strobe of any kind is issued when `vppOn` is 0 at the clock edge that sees the falling edge of `progN`.
- R6: `lockLvl` is {LB3, LB2, LB1}, where 1 means programmed. While any lock bit is programmed, code and key writes are suppressed. Lock-bit writes stay allowed.
- R7: In verify mode, `dataOe` is 1 one cycle after sampling. `dataOut` equals `codeRd` XNOR `keyRd`, and `keyRdAddr` always equals `addr[5:0]`.
- R8: While LB2 or LB3 is programmed, a verify read keeps `dataOe` at 0. LB1 alone does not block verify.
- R9: A signature read returns 58h at 030h, 57h at 031h, the part code (default ADh) at 060h, and FFh at 061h and at every other address.
- R10: A single falling edge of `progN` produces exactly one write strobe, however long `progN` then stays low.
- R11: During reset (`rstN`=0), every write strobe, `dataOe`, `dataOut`, `wrAddr` and `wrData` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinRst | input | 1 | Level of the reset pin (1 selects programming set-up) |
| pinPsen | input | 1 | Level of the program-store enable pin |
| ctrlPins | input | 5 | {P2.6, P2.7, P3.3, P3.6, P3.7} control levels |
| progN | input | 1 | Active-low program strobe |
| vppOn | input | 1 | Program voltage present flag |
| lockLvl | input | 3 | Programmed lock bits {LB3, LB2, LB1} |
| addr | input | 13 | Byte address |
| dataIn | input | 8 | Byte to program |
| codeRd | input | 8 | Code array byte at `addr` |
| keyRd | input | 8 | Key array byte at `keyRdAddr` |
| keyRdAddr | output | 6 | Key array read index |
| codeWe | output | 1 | Code array write strobe |
| keyWe | output | 1 | Key array write strobe |
| lockWe | output | 3 | Lock bit write strobes |
| wrAddr | output | 13 | Latched write address |
| wrData | output | 8 | Latched write data |
| dataOut | output | 8 | Read data |
| dataOe | output | 1 | Read data output enable |

## Verification
The assertions watch every cycle for the following:
- more than one write strobe high at once;
- a strobe held longer than one cycle;
- a strobe issued without the program voltage;
- a code or key write while any lock bit is set;
- a key write at or above 40h;
- a driven data output outside the programming set-up.

The values themselves can only be shown by the bench scenarios. These are the XNOR-scrambled verify byte, the signature table and its FFh default, the latched address and data, and the decode of each control pattern. The bench also shows that a verify read is blocked only by the upper two lock bits, and that lock programming still works while code writes are locked out.

// File: rtl/progseq_pkg.sv
package progseq_pkg;
  typedef enum logic [2:0] {
    MODE_IDLE,
    MODE_PGM_CODE,
    MODE_VERIFY,
    MODE_PGM_KEY,
    MODE_SIG,
    MODE_LOCK1,
    MODE_LOCK2,
    MODE_LOCK3
  } modeT;

  localparam int LOCK_N = 3;

  typedef struct packed {
    logic              codeWr;
    logic              keyWr;
    logic [LOCK_N-1:0] lockWr;
    logic              verifyRd;
    logic              sigRd;
  } strobeT;
endpackage

// File: rtl/progModeCtrl.sv
module progModeCtrl
  import progseq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int KEY_AW = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    pinRst,
  input  logic                    pinPsen,
  input  logic [4:0]              ctrlPins,
  input  logic                    progN,
  input  logic                    vppOn,
  input  logic [LOCK_N-1:0]       lockLvl,
  input  logic [ADDR_W-1:0]       addr,
  output strobeT                  stb
);
  modeT mode;
  logic progPrev;
  logic pgmEdge;
  logic unlocked;
  logic keyInRange;

  // Pin-level decode of the set-up mode
  always_comb begin
    mode = MODE_IDLE;
    if (pinRst && !pinPsen) begin
      case (ctrlPins)
        5'b01111: mode = MODE_PGM_CODE;
        5'b00111: mode = MODE_VERIFY;
        5'b01101: mode = MODE_PGM_KEY;
        5'b00000: mode = MODE_SIG;
        5'b11111: mode = MODE_LOCK1;
        5'b11100: mode = MODE_LOCK2;
        5'b10110: mode = MODE_LOCK3;
        default:  mode = MODE_IDLE;
      endcase
    end
  end

  // Strobe history for falling-edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) progPrev <= 1'b1;
    else       progPrev <= progN;
  end

  assign pgmEdge    = progPrev && !progN && vppOn;
  assign unlocked   = (lockLvl == '0);
  assign keyInRange = (addr[ADDR_W-1:KEY_AW] == '0);

  always_comb begin
    stb           = '0;
    stb.codeWr    = pgmEdge && unlocked && (mode == MODE_PGM_CODE);
    stb.keyWr     = pgmEdge && unlocked && keyInRange && (mode == MODE_PGM_KEY);
    stb.lockWr[0] = pgmEdge && (mode == MODE_LOCK1);
    stb.lockWr[1] = pgmEdge && (mode == MODE_LOCK2);
    stb.lockWr[2] = pgmEdge && (mode == MODE_LOCK3);
    stb.verifyRd  = (mode == MODE_VERIFY) && !lockLvl[1] && !lockLvl[2];
    stb.sigRd     = (mode == MODE_SIG);
  end
endmodule

// File: rtl/progModeDp.sv
module progModeDp
  import progseq_pkg::*;
#(
  parameter int          ADDR_W    = 13,
  parameter int          DATA_W    = 8,
  parameter int          KEY_AW    = 6,
  parameter logic [7:0]  PART_CODE = 8'hAD
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobeT               stb,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    dataIn,
  input  logic [DATA_W-1:0]    codeRd,
  input  logic [DATA_W-1:0]    keyRd,
  output logic [KEY_AW-1:0]    keyRdAddr,
  output logic                 codeWe,
  output logic                 keyWe,
  output logic [LOCK_N-1:0]    lockWe,
  output logic [ADDR_W-1:0]    wrAddr,
  output logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    dataOut,
  output logic                 dataOe
);
  localparam logic [ADDR_W-1:0] SIG_MFR  = ADDR_W'(12'h030);
  localparam logic [ADDR_W-1:0] SIG_FAM  = ADDR_W'(12'h031);
  localparam logic [ADDR_W-1:0] SIG_PART = ADDR_W'(12'h060);
  localparam logic [ADDR_W-1:0] SIG_REV  = ADDR_W'(12'h061);

  logic [DATA_W-1:0] sigByte;
  logic [DATA_W-1:0] rdByte;
  logic              anyWr;
  logic              anyRd;

  assign keyRdAddr = addr[KEY_AW-1:0];

  always_comb begin
    case (addr)
      SIG_MFR:  sigByte = DATA_W'(8'h58);
      SIG_FAM:  sigByte = DATA_W'(8'h57);
      SIG_PART: sigByte = DATA_W'(PART_CODE);
      SIG_REV:  sigByte = '1;
      default:  sigByte = '1;
    endcase
  end

  assign rdByte = stb.sigRd ? sigByte : ~(codeRd ^ keyRd);
  assign anyWr  = stb.codeWr || stb.keyWr || (|stb.lockWr);
  assign anyRd  = stb.verifyRd || stb.sigRd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeWe  <= 1'b0;
      keyWe   <= 1'b0;
      lockWe  <= '0;
      wrAddr  <= '0;
      wrData  <= '0;
      dataOut <= '0;
      dataOe  <= 1'b0;
    end else begin
      codeWe  <= stb.codeWr;
      keyWe   <= stb.keyWr;
      lockWe  <= stb.lockWr;
      if (anyWr) begin
        wrAddr <= addr;
        wrData <= dataIn;
      end
      dataOe  <= anyRd;
      dataOut <= anyRd ? rdByte : '0;
    end
  end
endmodule

// File: rtl/progModeSeq.sv
module progModeSeq
  import progseq_pkg::*;
#(
  parameter int          ADDR_W    = 13,
  parameter int          DATA_W    = 8,
  parameter int          KEY_AW    = 6,
  parameter logic [7:0]  PART_CODE = 8'hAD
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pinRst,
  input  logic                 pinPsen,
  input  logic [4:0]           ctrlPins,
  input  logic                 progN,
  input  logic                 vppOn,
  input  logic [2:0]           lockLvl,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    dataIn,
  input  logic [DATA_W-1:0]    codeRd,
  input  logic [DATA_W-1:0]    keyRd,
  output logic [KEY_AW-1:0]    keyRdAddr,
  output logic                 codeWe,
  output logic                 keyWe,
  output logic [2:0]           lockWe,
  output logic [ADDR_W-1:0]    wrAddr,
  output logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    dataOut,
  output logic                 dataOe
);
  strobeT stb;

  progModeCtrl #(.ADDR_W(ADDR_W), .KEY_AW(KEY_AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .pinRst(pinRst), .pinPsen(pinPsen),
    .ctrlPins(ctrlPins), .progN(progN), .vppOn(vppOn),
    .lockLvl(lockLvl), .addr(addr), .stb(stb)
  );

  progModeDp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_AW(KEY_AW),
               .PART_CODE(PART_CODE)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(addr), .dataIn(dataIn),
    .codeRd(codeRd), .keyRd(keyRd), .keyRdAddr(keyRdAddr),
    .codeWe(codeWe), .keyWe(keyWe), .lockWe(lockWe),
    .wrAddr(wrAddr), .wrData(wrData), .dataOut(dataOut), .dataOe(dataOe)
  );
endmodule

// File: rtl/progModeSeq_chk.sv
module progModeSeq_chk #(
  parameter int ADDR_W = 13,
  parameter int KEY_AW = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              pinRst,
  input logic              pinPsen,
  input logic              vppOn,
  input logic [2:0]        lockLvl,
  input logic              codeWe,
  input logic              keyWe,
  input logic [2:0]        lockWe,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              dataOe
);
  logic anyWe;
  assign anyWe = codeWe || keyWe || (|lockWe);

  AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({codeWe, keyWe, lockWe}));                              // R4
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    anyWe |=> !anyWe);                                               // R10
  AST_WE_NEEDS_VPP: assert property (@(posedge clk) disable iff (!rstN)
    anyWe |-> $past(vppOn));                                         // R5
  AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (codeWe || keyWe) |-> ($past(lockLvl) == 3'b000));               // R6
  AST_KEY_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    keyWe |-> (wrAddr[ADDR_W-1:KEY_AW] == '0));                      // R3
  AST_OE_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> $past(pinRst && !pinPsen));                           // R1
endmodule

bind progModeSeq progModeSeq_chk #(.ADDR_W(ADDR_W), .KEY_AW(KEY_AW)) u_chk (
  .clk(clk), .rstN(rstN), .pinRst(pinRst), .pinPsen(pinPsen),
  .vppOn(vppOn), .lockLvl(lockLvl), .codeWe(codeWe), .keyWe(keyWe),
  .lockWe(lockWe), .wrAddr(wrAddr), .dataOe(dataOe)
);

// File: tb/progModeSeq_tb.sv
module progModeSeq_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] C_CODE = 5'b01111, C_VER = 5'b00111, C_KEY = 5'b01101,
                         C_SIG = 5'b00000, C_L1 = 5'b11111, C_L2 = 5'b11100,
                         C_L3 = 5'b10110, C_BAD = 5'b01010;

  logic clk = 0, rstN = 0, pinRst = 0, pinPsen = 1, progN = 1, vppOn = 0;
  logic [4:0] ctrlPins = '0;
  logic [2:0] lockLvl = '0;
  logic [12:0] addr = '0;
  logic [7:0] dataIn = '0, codeRd = '0, keyRd = '0;
  logic [5:0] keyRdAddr;
  logic codeWe, keyWe, dataOe;
  logic [2:0] lockWe;
  logic [12:0] wrAddr;
  logic [7:0] wrData, dataOut;

  int checks = 0, errors = 0;
  bit done = 0;
  logic sCode, sKey, sAny2;
  logic [2:0] sLock;
  logic [12:0] sAddr;
  logic [7:0] sData;

  always #(CLK_PERIOD/2) clk = ~clk;

  progModeSeq u_dut (.*);

  function automatic logic [7:0] expSig(input logic [12:0] a);
    case (a)
      13'h030: return 8'h58;
      13'h031: return 8'h57;
      13'h060: return 8'hAD;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] expVer(input logic [7:0] c, input logic [7:0] k);
    return ~(c ^ k);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setup(input logic [4:0] c);
    pinRst = 1; pinPsen = 0; ctrlPins = c;
  endtask

  // One program pulse; captures strobes in the cycle after the edge and the one after that
  task automatic pulse();
    @(negedge clk); progN = 0;
    @(posedge clk); @(negedge clk);
    sCode = codeWe; sKey = keyWe; sLock = lockWe; sAddr = wrAddr; sData = wrData;
    @(posedge clk); @(negedge clk);
    sAny2 = codeWe | keyWe | (|lockWe);
    progN = 1;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic rd(input logic [12:0] a, input logic [7:0] c, input logic [7:0] k);
    addr = a; codeRd = c; keyRd = k;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 strobes", {codeWe, keyWe, lockWe}, 0);
    chk("R11 oe/out", {dataOe, dataOut}, 0);
    chk("R11 wrAddr/wrData", {wrAddr, wrData}, 0);
    rstN = 1;
    @(negedge clk);

    // R1 unlisted pattern: no write, no output
    setup(C_BAD); vppOn = 1; addr = 13'h10; dataIn = 8'h5A;
    pulse();
    chk("R1 idle no write", {sCode, sKey, sLock}, 0);
    chk("R1 idle oe", {dataOe, dataOut}, 0);
    // R1 psen high blocks verify decode
    pinPsen = 1; ctrlPins = C_VER; rd(13'h5, 8'h12, 8'h34);
    chk("R1 psen blocks oe", dataOe, 0);

    // R2 / R10 random code programming
    setup(C_CODE);
    for (int i = 0; i < 6; i++) begin
      logic [12:0] a; logic [7:0] d;
      a = 13'($urandom); d = 8'($urandom);
      addr = a; dataIn = d;
      pulse();
      chk("R2 codeWe", {sCode, sKey, sLock}, 5'b10000);
      chk("R2 wrAddr", sAddr, a);
      chk("R2 wrData", sData, d);
      chk("R10 single strobe", sAny2, 0);
    end

    // R5 no voltage
    vppOn = 0; addr = 13'h22; pulse();
    chk("R5 no vpp", {sCode, sKey, sLock}, 0);
    vppOn = 1;

    // R3 key range boundary
    setup(C_KEY); addr = 13'h03F; dataIn = 8'hC3; pulse();
    chk("R3 key 3Fh", {sCode, sKey, sLock}, 5'b01000);
    chk("R3 key addr", sAddr, 13'h03F);
    addr = 13'h040; pulse();
    chk("R3 key 40h ignored", {sCode, sKey, sLock}, 0);

    // R4 lock bits
    setup(C_L1); pulse(); chk("R4 lock1", {sCode, sKey, sLock}, 5'b00001);
    setup(C_L2); pulse(); chk("R4 lock2", {sCode, sKey, sLock}, 5'b00010);
    setup(C_L3); pulse(); chk("R4 lock3", {sCode, sKey, sLock}, 5'b00100);

    // R6 lock level blocks code/key but not lock writes
    lockLvl = 3'b001;
    setup(C_CODE); addr = 13'h100; pulse();
    chk("R6 code locked", {sCode, sKey, sLock}, 0);
    setup(C_KEY); addr = 13'h001; pulse();
    chk("R6 key locked", {sCode, sKey, sLock}, 0);
    setup(C_L2); pulse();
    chk("R6 lock still ok", {sCode, sKey, sLock}, 5'b00010);

    // R8 verify with LB1 only is allowed; LB2 / LB3 block it
    setup(C_VER); rd(13'h7, 8'hF0, 8'hFF);
    chk("R8 LB1 verify oe", dataOe, 1);
    chk("R8 LB1 verify data", dataOut, expVer(8'hF0, 8'hFF));
    lockLvl = 3'b010; rd(13'h8, 8'h11, 8'h22);
    chk("R8 LB2 blocks", {dataOe, dataOut}, 0);
    lockLvl = 3'b100; rd(13'h9, 8'h11, 8'h22);
    chk("R8 LB3 blocks", {dataOe, dataOut}, 0);
    lockLvl = 3'b000;

    // R7 random verify
    for (int i = 0; i < 20; i++) begin
      logic [12:0] a; logic [7:0] c, k;
      a = 13'($urandom); c = 8'($urandom); k = 8'($urandom);
      rd(a, c, k);
      chk("R7 verify oe", dataOe, 1);
      chk("R7 verify data", dataOut, expVer(c, k));
      chk("R7 key index", keyRdAddr, a[5:0]);
    end

    // R9 signature table and default
    setup(C_SIG);
    rd(13'h030, 8'h00, 8'h00); chk("R9 sig 30h", {dataOe, dataOut}, {1'b1, expSig(13'h030)});
    rd(13'h031, 8'h00, 8'h00); chk("R9 sig 31h", dataOut, expSig(13'h031));
    rd(13'h060, 8'h00, 8'h00); chk("R9 sig 60h", dataOut, expSig(13'h060));
    rd(13'h061, 8'h00, 8'h00); chk("R9 sig 61h", dataOut, expSig(13'h061));
    for (int i = 0; i < 10; i++) begin
      logic [12:0] a;
      a = 13'($urandom);
      rd(a, 8'h00, 8'h00);
      chk("R9 sig random", dataOut, expSig(a));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule